// File: doc/BRIEF.md
# Control-Channel Register Decoder with Activation Requests

Once per serial-bus frame a transceiver receives one control byte. This block accepts that byte on a valid/ready input. The two least significant bits of the byte pick one of two control registers, and the upper six bits are stored in the register they pick. The stored fields are decoded into plain control outputs:

- B-channel swap
- CRC corruption
- the line start/stop level
- A/D gain
- mode swap
- a four-bit diagnostic code
- a status-register selector

The block also watches two fields for edges. A rising or falling start/stop bit becomes a single-cycle activation or deactivation request, but only in the transceiver state that allows it. A 1-to-0 transition of the superframe-reset bit in line-termination mode becomes a one-shot superframe counter reset. The counter reset and any change of status selector wait for the next frame strobe. The activation state machine and the datapath that use these outputs are outside the block.

The input handshake never applies back-pressure. `cc_ready` is low during reset and stays high from the first clock edge after reset is released. Each byte accepted with `cc_valid && cc_ready` is acted on at that edge. A producer must hold `cc_data` stable while `cc_valid` is high and the byte is not yet accepted.

Top module: `ctl_chan_regs`

## Requirements
- R1: While `rst_n` is low, every output is 0, including `cc_ready`. After release, `cc_ready` is 1 from the first clock edge onward and stays 1.
- R2: An accepted byte with bits[1:0]=00 writes register A and one with 01 writes register B. A byte with bits[1:0]=10 or 11 changes no output and raises no request. Each register holds its value until a byte addresses it again.
- R3: Register A fields appear on the outputs in the cycle after the accepting edge: bit 4 drives `b_swap`, bit 3 drives `crc_corrupt` and bit 2 drives `line_start`.
- R4: Register B fields appear in the cycle after the accepting edge: bits[7:4] drive `diag_code`, bit 3 drives `adc_gain` and bit 2 drives `mode_swap`.
- R5: Register A bits[7:6] reach `stat_sel` only at the first clock edge that samples `frame_strb`=1 after the accepting edge. A strobe on the accepting edge itself does not count. Between such strobes `stat_sel` does not change.
- R6: A register A write that takes bit 2 from 0 to 1 while `xcvr_state`=00 (full reset) raises `act_req` for exactly one cycle, the cycle after the accepting edge. In any other state, or without a 0-to-1 change, no `act_req` follows.
- R7: A register A write that takes bit 2 from 1 to 0 while `xcvr_state`=10 (active) raises `deact_req` for exactly one cycle, the cycle after the accepting edge. In any other state, or without a 1-to-0 change, no `deact_req` follows.
- R8: A register A write that takes bit 5 from 1 to 0 while `lt_mode`=1 arms a superframe reset. `sf_reset` is then 1 for exactly one cycle after the next strobe edge. With `lt_mode`=0, or for a 0-to-1 change, nothing is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cc_valid | input | 1 | Control byte valid |
| cc_ready | output | 1 | Control byte accepted when high with valid |
| cc_data | input | 8 | Control byte; bits[1:0] select the register |
| frame_strb | input | 1 | One-cycle frame boundary strobe |
| lt_mode | input | 1 | 1 = line-termination mode, 0 = network-termination mode |
| xcvr_state | input | 2 | Transceiver state: 00 full reset, 01 activating, 10 active, 11 deactivating |
| stat_sel | output | 2 | Status register selector for the next frame |
| sf_reset | output | 1 | One-cycle superframe counter reset |
| b_swap | output | 1 | Exchange B1 and B2 slots in both directions |
| crc_corrupt | output | 1 | Corrupt the transmitted 12-bit CRC |
| line_start | output | 1 | Stored start/stop level |
| act_req | output | 1 | One-cycle activation request |
| deact_req | output | 1 | One-cycle deactivation request |
| adc_gain | output | 1 | Extra A/D gain for long loops |
| mode_swap | output | 1 | Make a line-termination unit behave as a network-termination unit |
| diag_code | output | 4 | Diagnostic select code |

## Verification
Level fields and the two activation-type requests are due one cycle after the accepting edge. The bench drives the byte on a falling edge, lets the next rising edge accept it, and compares on the falling edge that follows. It then compares again one cycle later to confirm that each request has dropped. `stat_sel` and `sf_reset` are due one cycle after a strobe edge, so the bench also confirms that a write alone leaves them unchanged until a strobe is driven. The sweep walks 1024 byte/state/mode combinations. Each combination is followed by a strobe, so every armed superframe reset is collected before the next write.

// File: rtl/cc_pkg.sv
package cc_pkg;
  // Transceiver states as seen on xcvr_state
  typedef enum logic [1:0] {
    XS_FULLRST = 2'b00,
    XS_ACTING  = 2'b01,
    XS_ACTIVE  = 2'b10,
    XS_DEACTING = 2'b11
  } xcvr_st_e;

  // Field positions inside a stored register (byte bits minus the select bits)
  localparam int unsigned SEL_BITS  = 2;
  localparam int unsigned A_STAT_HI = 7 - SEL_BITS;
  localparam int unsigned A_STAT_LO = 6 - SEL_BITS;
  localparam int unsigned A_SFRST   = 5 - SEL_BITS;
  localparam int unsigned A_BSWAP   = 4 - SEL_BITS;
  localparam int unsigned A_CRC     = 3 - SEL_BITS;
  localparam int unsigned A_START   = 2 - SEL_BITS;
  localparam int unsigned B_DIAG_HI = 7 - SEL_BITS;
  localparam int unsigned B_DIAG_LO = 4 - SEL_BITS;
  localparam int unsigned B_ADC     = 3 - SEL_BITS;
  localparam int unsigned B_MSWAP   = 2 - SEL_BITS;
endpackage

// File: rtl/cc_reg_bank.sv
module cc_reg_bank #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned NREG   = 2,
  localparam int unsigned PAY_W = BYTE_W - SEL_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [BYTE_W-1:0]           data,
  output logic [NREG-1:0]             hit,
  output logic [NREG-1:0][PAY_W-1:0]  q
);
  logic [SEL_W-1:0] sel;
  logic [PAY_W-1:0] pay;
  assign sel = data[SEL_W-1:0];
  assign pay = data[BYTE_W-1:SEL_W];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = wr && (sel == SEL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)      q[g] <= '0;
      else if (hit[g]) q[g] <= pay;
    end
  end
endmodule

// File: rtl/cc_edge_req.sv
module cc_edge_req #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic old_bit,
  input  logic new_bit,
  input  logic qual,
  output logic req
);
  logic edge_seen;
  if (RISING) begin : g_rise
    assign edge_seen = !old_bit && new_bit;
  end else begin : g_fall
    assign edge_seen = old_bit && !new_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req <= 1'b0;
    else        req <= wr && edge_seen && qual;
  end
endmodule

// File: rtl/cc_frame_sync.sv
module cc_frame_sync #(
  parameter int unsigned STAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic              arm,
  input  logic [STAT_W-1:0] stat_next,
  output logic [STAT_W-1:0] stat_sel,
  output logic              sf_reset
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      stat_sel <= '0;
      sf_reset <= 1'b0;
    end else begin
      sf_reset <= strb && pend_q;
      if (strb) stat_sel <= stat_next;
      if (arm)       pend_q <= 1'b1;
      else if (strb) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_chan_regs.sv
module ctl_chan_regs
  import cc_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned STAT_W = 2,
  parameter int unsigned DIAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cc_valid,
  output logic              cc_ready,
  input  logic [BYTE_W-1:0] cc_data,
  input  logic              frame_strb,
  input  logic              lt_mode,
  input  logic [1:0]        xcvr_state,
  output logic [STAT_W-1:0] stat_sel,
  output logic              sf_reset,
  output logic              b_swap,
  output logic              crc_corrupt,
  output logic              line_start,
  output logic              act_req,
  output logic              deact_req,
  output logic              adc_gain,
  output logic              mode_swap,
  output logic [DIAG_W-1:0] diag_code
);
  localparam int unsigned NREG  = 2;
  localparam int unsigned PAY_W = BYTE_W - SEL_BITS;
  localparam int unsigned REG_A = 0;
  localparam int unsigned REG_B = 1;

  logic                       rdy_q;
  logic                       wr;
  logic [NREG-1:0]            hit;
  logic [NREG-1:0][PAY_W-1:0] regs_q;
  logic [PAY_W-1:0]           new_pay;
  logic                       sf_arm;

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign cc_ready = rdy_q;
  assign wr       = cc_valid && rdy_q;
  assign new_pay  = cc_data[BYTE_W-1:SEL_BITS];

  cc_reg_bank #(.BYTE_W(BYTE_W), .SEL_W(SEL_BITS), .NREG(NREG)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr(wr), .data(cc_data), .hit(hit), .q(regs_q)
  );

  cc_edge_req #(.RISING(1'b1)) u_act (
    .clk(clk), .rst_n(rst_n), .wr(hit[REG_A]),
    .old_bit(regs_q[REG_A][A_START]), .new_bit(new_pay[A_START]),
    .qual(xcvr_state == XS_FULLRST), .req(act_req)
  );

  cc_edge_req #(.RISING(1'b0)) u_deact (
    .clk(clk), .rst_n(rst_n), .wr(hit[REG_A]),
    .old_bit(regs_q[REG_A][A_START]), .new_bit(new_pay[A_START]),
    .qual(xcvr_state == XS_ACTIVE), .req(deact_req)
  );

  assign sf_arm = hit[REG_A] && lt_mode &&
                  regs_q[REG_A][A_SFRST] && !new_pay[A_SFRST];

  cc_frame_sync #(.STAT_W(STAT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .strb(frame_strb), .arm(sf_arm),
    .stat_next(regs_q[REG_A][A_STAT_HI:A_STAT_LO]),
    .stat_sel(stat_sel), .sf_reset(sf_reset)
  );

  assign b_swap      = regs_q[REG_A][A_BSWAP];
  assign crc_corrupt = regs_q[REG_A][A_CRC];
  assign line_start  = regs_q[REG_A][A_START];
  assign diag_code   = regs_q[REG_B][B_DIAG_HI:B_DIAG_LO];
  assign adc_gain    = regs_q[REG_B][B_ADC];
  assign mode_swap   = regs_q[REG_B][B_MSWAP];
endmodule

// File: rtl/cc_chk.sv
module cc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cc_valid,
  input logic       cc_ready,
  input logic [7:0] cc_data,
  input logic       frame_strb,
  input logic       lt_mode,
  input logic [1:0] xcvr_state,
  input logic [1:0] stat_sel,
  input logic       sf_reset,
  input logic       b_swap,
  input logic       crc_corrupt,
  input logic       line_start,
  input logic       act_req,
  input logic       deact_req,
  input logic       adc_gain,
  input logic       mode_swap,
  input logic [3:0] diag_code
);
  a_r6_act_gated: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |-> line_start && !$past(line_start) && $past(xcvr_state) == 2'b00);

  a_r6_act_single: assert property (@(posedge clk) disable iff (!rst_n)
    act_req |=> !act_req);

  a_r7_deact_gated: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |-> !line_start && $past(line_start) && $past(xcvr_state) == 2'b10);

  a_r7_deact_single: assert property (@(posedge clk) disable iff (!rst_n)
    deact_req |=> !deact_req);

  a_r8_sf_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    sf_reset |-> $past(frame_strb));

  a_r5_stat_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_sel != $past(stat_sel)) |-> $past(frame_strb));

  a_r2_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_ready && cc_data[1]) |=>
      $stable(b_swap) && $stable(crc_corrupt) && $stable(line_start) &&
      $stable(adc_gain) && $stable(mode_swap) && $stable(diag_code) &&
      !act_req && !deact_req);
endmodule

bind ctl_chan_regs cc_chk u_chk (.*);

// File: tb/sim_ctl_chan_regs.sv
`timescale 1ns/1ps
module sim_ctl_chan_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cc_valid = 1'b0;
  logic       cc_ready;
  logic [7:0] cc_data = '0;
  logic       frame_strb = 1'b0;
  logic       lt_mode = 1'b0;
  logic [1:0] xcvr_state = 2'b00;
  logic [1:0] stat_sel;
  logic       sf_reset, b_swap, crc_corrupt, line_start;
  logic       act_req, deact_req, adc_gain, mode_swap;
  logic [3:0] diag_code;

  always #2.5 clk = ~clk;

  ctl_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .cc_valid(cc_valid), .cc_ready(cc_ready),
    .cc_data(cc_data), .frame_strb(frame_strb), .lt_mode(lt_mode),
    .xcvr_state(xcvr_state), .stat_sel(stat_sel), .sf_reset(sf_reset),
    .b_swap(b_swap), .crc_corrupt(crc_corrupt), .line_start(line_start),
    .act_req(act_req), .deact_req(deact_req), .adc_gain(adc_gain),
    .mode_swap(mode_swap), .diag_code(diag_code)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] e_a = '0;
  logic [7:0] e_b = '0;
  logic [1:0] e_stat = '0;
  bit e_sfp = 1'b0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fields_chk();
    chk("R3 b_swap", 8'(b_swap), 8'(e_a[4]));
    chk("R3 crc_corrupt", 8'(crc_corrupt), 8'(e_a[3]));
    chk("R3 line_start", 8'(line_start), 8'(e_a[2]));
    chk("R4 diag_code", 8'(diag_code), 8'(e_b[7:4]));
    chk("R4 adc_gain", 8'(adc_gain), 8'(e_b[3]));
    chk("R4 mode_swap", 8'(mode_swap), 8'(e_b[2]));
    chk("R5 stat_sel held", 8'(stat_sel), 8'(e_stat));
  endtask

  task automatic wr(logic [7:0] b, logic [1:0] st, logic lt);
    bit x_act, x_deact;
    x_act = 0; x_deact = 0;
    @(negedge clk);
    cc_valid = 1'b1; cc_data = b; xcvr_state = st; lt_mode = lt;
    if (b[1:0] == 2'b00) begin
      x_act   = b[2] && !e_a[2] && st == 2'b00;
      x_deact = !b[2] && e_a[2] && st == 2'b10;
      if (lt && e_a[5] && !b[5]) e_sfp = 1'b1;
      e_a = b;
    end else if (b[1:0] == 2'b01) begin
      e_b = b;
    end
    @(negedge clk);
    cc_valid = 1'b0;
    chk("R6 act_req pulse", 8'(act_req), 8'(x_act));
    chk("R7 deact_req pulse", 8'(deact_req), 8'(x_deact));
    chk("R8 sf_reset waits for strobe", 8'(sf_reset), 8'h0);
    fields_chk();
    @(negedge clk);
    chk("R6 act_req one cycle", 8'(act_req), 8'h0);
    chk("R7 deact_req one cycle", 8'(deact_req), 8'h0);
  endtask

  task automatic strobe();
    @(negedge clk);
    frame_strb = 1'b1;
    @(negedge clk);
    frame_strb = 1'b0;
    e_stat = e_a[7:6];
    chk("R5 stat_sel at strobe", 8'(stat_sel), 8'(e_stat));
    chk("R8 sf_reset at strobe", 8'(sf_reset), 8'(e_sfp));
    e_sfp = 1'b0;
    @(negedge clk);
    chk("R8 sf_reset one cycle", 8'(sf_reset), 8'h0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 8'(cc_ready), 8'h0);
    chk("R1 act_req in reset", 8'(act_req), 8'h0);
    fields_chk();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 8'(cc_ready), 8'h1);

    // R6: rise outside full reset is ignored, then accepted in full reset
    wr(8'h04, 2'b01, 1'b0);
    wr(8'h00, 2'b00, 1'b0);
    wr(8'h04, 2'b00, 1'b0);
    // R7: fall outside active ignored; rise again; fall in active accepted
    wr(8'h00, 2'b00, 1'b0);
    wr(8'h04, 2'b00, 1'b0);
    wr(8'h04, 2'b00, 1'b0);   // same value: no edge
    wr(8'h00, 2'b10, 1'b0);
    // R2: unmapped selects change nothing
    wr(8'hFE, 2'b00, 1'b1);
    wr(8'hFF, 2'b10, 1'b1);
    chk("R2 unmapped b_swap", 8'(b_swap), 8'h0);
    // R8: NT mode falling bit 5 ignored, LT mode accepted
    wr(8'h20, 2'b11, 1'b0);
    wr(8'h00, 2'b11, 1'b0);
    strobe();
    wr(8'h20, 2'b11, 1'b1);
    wr(8'hC0, 2'b11, 1'b1);
    chk("R5 stat before strobe", 8'(stat_sel), 8'(e_stat));
    strobe();
    // R4: register B
    wr(8'hAD, 2'b00, 1'b0);
    wr(8'h51, 2'b00, 1'b0);

    // Near-exhaustive sweep over byte, state and mode
    for (int i = 0; i < 1024; i++) begin
      logic [7:0] b;
      b = 8'((i * 37) + (i >> 3));
      wr(b, 2'(i >> 8), i[0] ^ i[5]);
      strobe();
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule